// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block keeps the per-function vector table and pending-bit array of a message-signalled interrupt function with an independent table per vector. Software reaches both structures through a 32-bit register port. One select line picks the table and another picks the pending array. The function-level enable and mask-all bits come in as plain inputs from the configuration logic. Device logic raises a request by vector number. For each request the block either offers the vector's stored 64-bit address and 32-bit data on a valid/ready message port, or parks the request as a pending bit.

The block holds one pending bit per vector. A vector is "ready" when its pending bit is set and its effective mask is clear. The effective mask is the vector's own mask bit ORed with the function mask. The lowest-numbered ready vector is offered on the message port, and its pending bit is cleared only when the port accepts the message. As a result, a new request on an unmasked vector, a per-vector unmask written to the table, and a function-level unmask all drain the same way: ascending vector order, one message per handshake.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset, every vector's control word reads 1 (mask set), all address and data words read 0, the pending array reads 0 and `msg_valid` is low.
- R2: The entry for vector v starts at byte 16·v of the table. Inside it, the word at +0 is the low 32 bits of the address, +4 the high 32 bits, +8 the data, and +12 the control word, whose bit 0 is the vector mask. A write changes only the addressed word, and reads return what was written (other control bits read 0).
- R3: The function is masked while `fn_enable` is 0 or `fn_maskall` is 1. No message is offered while it is masked, and requests made during that time are kept as pending bits.
- R4: A request on an in-use, unmasked vector offers that vector's {high, low} address, data and number on the message port in the cycle after the request. Its pending bit stays set until the handshake and is clear afterwards.
- R5: The pending array holds vector v at bit v mod 32 of the 32-bit word at byte offset 4·(v/32), which is bit v mod 8 of byte v/8. A request on a masked vector sets that bit.
- R6: Clearing a vector's mask bit while its pending bit is set offers that vector's message. The pending bit is cleared when the message is accepted.
- R7: When several vectors are ready, messages are offered in ascending vector order, one per accepted handshake. On a function-level unmask, vectors whose own mask is still set stay pending.
- R8: A request whose vector number is NUM_VEC or above, or whose `vec_used` bit is 0, changes no pending bit and produces no message.
- R9: Writes to the pending array have no effect, and pending-array words beyond the vector count read 0.
- R10: `tbl_size` reports NUM_VEC−1. NUM_VEC must lie in 1..2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fn_enable | input | 1 | Function enable bit |
| fn_maskall | input | 1 | Function mask-all bit |
| vec_used | input | NUM_VEC | Per-vector in-use flags |
| reg_sel_tbl | input | 1 | Register access targets the vector table |
| reg_sel_pba | input | 1 | Register access targets the pending array |
| reg_wr | input | 1 | Write strobe for the selected structure |
| reg_addr | input | AW | Byte address inside the selected structure (bits 1:0 ignored) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address, combinational |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | 11 | Requested vector number |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_vec | output | 11 | Vector number of the offered message |
| tbl_size | output | 11 | Vector count minus one |

## Verification
The main send-or-park decision is driven with four patterns:
- A request on a fully unmasked vector, which separates the immediate-offer path from parking.
- Requests while only the function is masked and while only the vector is masked, which shows that each mask source on its own causes parking.
- A per-vector unmask written to the table over a parked request, which exercises replay triggered by a table write.
- A function-level unmask over several parked vectors, some still self-masked, which separates ascending-order drain from wrong ordering and from over-eager release.

Dropped requests (out of range and unused) and pending-array writes are checked both at the message port and by reading back the pending array.

// File: rtl/msix_vc_pkg.sv
package msix_vc_pkg;
   localparam int VEC_W   = 11;
   localparam int MAX_VEC = 2048;

   typedef struct packed {
      logic [31:0] adr_lo;
      logic [31:0] adr_hi;
      logic [31:0] dat;
      logic        msk;
   } vec_entry_t;
endpackage

// File: rtl/msix_vc_table.sv
module msix_vc_table
   import msix_vc_pkg::*;
#(
   parameter int NUM_VEC = 8,
   parameter int AW      = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   output logic [NUM_VEC-1:0] ent_mask,
   input  logic [NUM_VEC-1:0] pick_oh,
   output logic [63:0]        pick_addr,
   output logic [31:0]        pick_data
);
   localparam int IDXW = AW - 4;

   logic [IDXW-1:0] idx;
   logic [1:0]      wsel;
   vec_entry_t      ent_arr [NUM_VEC];

   assign idx  = addr[AW-1:4];
   assign wsel = addr[3:2];

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
      vec_entry_t ent;
      logic       hit;
      assign hit = wr_en && (idx == IDXW'(v));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent <= '{adr_lo: '0, adr_hi: '0, dat: '0, msk: 1'b1};
         end else if (hit) begin
            case (wsel)
               2'd0:    ent.adr_lo <= wdata;
               2'd1:    ent.adr_hi <= wdata;
               2'd2:    ent.dat    <= wdata;
               default: ent.msk    <= wdata[0];
            endcase
         end
      end
      assign ent_arr[v]  = ent;
      assign ent_mask[v] = ent.msk;
   end

   always_comb begin
      rdata = '0;
      for (int v = 0; v < NUM_VEC; v++) begin
         if (idx == IDXW'(v)) begin
            case (wsel)
               2'd0:    rdata = ent_arr[v].adr_lo;
               2'd1:    rdata = ent_arr[v].adr_hi;
               2'd2:    rdata = ent_arr[v].dat;
               default: rdata = {31'd0, ent_arr[v].msk};
            endcase
         end
      end
   end

   always_comb begin
      pick_addr = '0;
      pick_data = '0;
      for (int v = 0; v < NUM_VEC; v++) begin
         if (pick_oh[v]) begin
            pick_addr = pick_addr | {ent_arr[v].adr_hi, ent_arr[v].adr_lo};
            pick_data = pick_data | ent_arr[v].dat;
         end
      end
   end
endmodule

// File: rtl/msix_vc_pend.sv
module msix_vc_pend #(
   parameter int NUM_VEC = 8,
   parameter int AW      = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] set_oh,
   input  logic [NUM_VEC-1:0] clr_oh,
   input  logic [AW-1:0]      addr,
   output logic [31:0]        rdata,
   output logic [NUM_VEC-1:0] pend
);
   localparam int PBA_WORDS = ((NUM_VEC + 63) / 64) * 2;
   localparam int PAD_W     = PBA_WORDS * 32;

   logic [PAD_W-1:0] padded;
   logic [AW-3:0]    widx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr_oh) | set_oh;
   end

   assign padded = PAD_W'(pend);
   assign widx   = addr[AW-1:2];

   always_comb begin
      rdata = '0;
      for (int w = 0; w < PBA_WORDS; w++) begin
         if (widx == (AW-2)'(w)) rdata = padded[w*32 +: 32];
      end
   end

   // R9: only requests and accepts move the array; register writes never do
   a_r9_pba_writes_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (set_oh == '0 && clr_oh == '0) |=> $stable(pend));
endmodule

// File: rtl/msix_vc_pick.sv
module msix_vc_pick
   import msix_vc_pkg::*;
#(
   parameter int NUM_VEC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] req,
   output logic               any,
   output logic [NUM_VEC-1:0] grant,
   output logic [VEC_W-1:0]   idx
);
   logic [NUM_VEC:0] seen;
   assign seen[0] = 1'b0;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_chain
      assign grant[v]  = req[v] & ~seen[v];
      assign seen[v+1] = seen[v] | req[v];
   end

   assign any = seen[NUM_VEC];

   always_comb begin
      idx = '0;
      for (int v = 0; v < NUM_VEC; v++) begin
         if (grant[v]) idx = VEC_W'(v);
      end
   end

   // R7: exactly one vector offered whenever any is ready
   a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> $onehot(grant));
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
   import msix_vc_pkg::*;
#(
   parameter int NUM_VEC = 8,
   parameter int IDXW    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
   parameter int AW      = IDXW + 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fn_enable,
   input  logic               fn_maskall,
   input  logic [NUM_VEC-1:0] vec_used,
   input  logic               reg_sel_tbl,
   input  logic               reg_sel_pba,
   input  logic               reg_wr,
   input  logic [AW-1:0]      reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               irq_req,
   input  logic [VEC_W-1:0]   irq_vec,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [63:0]        msg_addr,
   output logic [31:0]        msg_data,
   output logic [VEC_W-1:0]   msg_vec,
   output logic [VEC_W-1:0]   tbl_size
);
   if (NUM_VEC < 1 || NUM_VEC > MAX_VEC) begin : g_bad_count
      $error("NUM_VEC must lie in 1..2048");
   end
   if (AW < IDXW + 4) begin : g_bad_aw
      $error("AW too narrow for the vector table");
   end

   logic               fn_masked;
   logic [NUM_VEC-1:0] ent_mask, eff_mask, pend, ready_v, grant, set_oh, clr_oh;
   logic [31:0]        tbl_rdata, pba_rdata;

   assign fn_masked = !fn_enable || fn_maskall;
   assign eff_mask  = ent_mask | {NUM_VEC{fn_masked}};
   assign ready_v   = pend & ~eff_mask;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_req
      assign set_oh[v] = irq_req && vec_used[v] && (irq_vec == VEC_W'(v));
   end
   assign clr_oh = grant & {NUM_VEC{msg_ready}};

   msix_vc_table #(.NUM_VEC(NUM_VEC), .AW(AW)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr && reg_sel_tbl),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (tbl_rdata),
      .ent_mask  (ent_mask),
      .pick_oh   (grant),
      .pick_addr (msg_addr),
      .pick_data (msg_data)
   );

   msix_vc_pend #(.NUM_VEC(NUM_VEC), .AW(AW)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_oh (set_oh),
      .clr_oh (clr_oh),
      .addr   (reg_addr),
      .rdata  (pba_rdata),
      .pend   (pend)
   );

   msix_vc_pick #(.NUM_VEC(NUM_VEC)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (ready_v),
      .any   (msg_valid),
      .grant (grant),
      .idx   (msg_vec)
   );

   assign reg_rdata = reg_sel_tbl ? tbl_rdata : (reg_sel_pba ? pba_rdata : 32'd0);
   assign tbl_size  = VEC_W'(NUM_VEC - 1);

   // R3: a masked function never offers a message
   a_r3_fn_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      fn_masked |-> !msg_valid);

   // R4: an accepted vector leaves the pending array unless re-requested
   a_r4_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready && !irq_req) |=> ((pend & $past(grant)) == '0));

   // R5: a valid request always leaves its pending bit set or its message offered
   a_r5_request_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      (set_oh != '0) |=> ((pend & $past(set_oh)) != '0));

   // R8: out-of-range requests do not touch the pending array
   a_r8_drop_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_vec >= VEC_W'(NUM_VEC) && !(msg_valid && msg_ready))
      |=> (pend == $past(pend)));
endmodule

// File: tb/msix_vec_ctrl_tb.sv
module msix_vec_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;
   localparam int AW = 7;

   logic          clk = 0, rst_n = 0;
   logic          fn_enable = 0, fn_maskall = 0;
   logic [NV-1:0] vec_used = 8'h7F;
   logic          reg_sel_tbl = 0, reg_sel_pba = 0, reg_wr = 0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0, reg_rdata;
   logic          irq_req = 0;
   logic [10:0]   irq_vec = '0;
   logic          msg_valid, msg_ready = 0;
   logic [63:0]   msg_addr;
   logic [31:0]   msg_data;
   logic [10:0]   msg_vec, tbl_size;

   int n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   msix_vec_ctrl #(.NUM_VEC(NV)) u_dut (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_lo(int v); return 32'h1000_0000 + v*16; endfunction
   function automatic logic [31:0] exp_hi(int v); return 32'h0000_00A0 + v; endfunction
   function automatic logic [31:0] exp_dat(int v); return 32'h0000_D000 + v; endfunction

   task automatic wr(input bit tbl, input int addr, input logic [31:0] d);
      @(negedge clk);
      reg_sel_tbl = tbl; reg_sel_pba = !tbl; reg_addr = AW'(addr); reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0; reg_sel_tbl = 0; reg_sel_pba = 0;
   endtask

   task automatic rd(input bit tbl, input int addr, output logic [31:0] d);
      @(negedge clk);
      reg_sel_tbl = tbl; reg_sel_pba = !tbl; reg_addr = AW'(addr);
      #1 d = reg_rdata;
      reg_sel_tbl = 0; reg_sel_pba = 0;
   endtask

   task automatic irq(input int v);
      @(negedge clk);
      irq_req = 1; irq_vec = 11'(v);
      @(negedge clk);
      irq_req = 0;
   endtask

   task automatic set_fn(input logic en, input logic ma);
      @(negedge clk);
      fn_enable = en; fn_maskall = ma;
   endtask

   task automatic take(input string tag, input int v);
      #1;
      chk({tag, " valid"}, 64'(msg_valid), 64'd1);
      chk({tag, " vec"},   64'(msg_vec),   64'(v));
      chk({tag, " addr"},  msg_addr,       {exp_hi(v), exp_lo(v)});
      chk({tag, " data"},  64'(msg_data),  64'(exp_dat(v)));
      @(negedge clk);
      msg_ready = 1;
      @(negedge clk);
      msg_ready = 0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      #1 chk("R1 valid after reset", 64'(msg_valid), 64'd0);
      for (int v = 0; v < NV; v++) begin
         rd(1, v*16 + 12, d); chk("R1 mask set", 64'(d), 64'd1);
         rd(1, v*16 + 8, d);  chk("R1 data zero", 64'(d), 64'd0);
      end
      rd(0, 0, d); chk("R1 pba zero", 64'(d), 64'd0);
      chk("R10 table size", 64'(tbl_size), 64'(NV-1));
   endtask

   task automatic t_program;
      logic [31:0] d;
      for (int v = 0; v < NV; v++) begin
         wr(1, v*16 + 0, exp_lo(v));
         wr(1, v*16 + 4, exp_hi(v));
         wr(1, v*16 + 8, exp_dat(v));
      end
      for (int v = 0; v < NV; v++) begin
         rd(1, v*16 + 0, d); chk("R2 addr lo", 64'(d), 64'(exp_lo(v)));
         rd(1, v*16 + 4, d); chk("R2 addr hi", 64'(d), 64'(exp_hi(v)));
      end
      wr(1, 2*16 + 12, 32'hFFFF_FFFF);
      rd(1, 2*16 + 12, d); chk("R2 ctrl only bit0", 64'(d), 64'd1);
      rd(1, 2*16 + 8, d);  chk("R2 neighbour word kept", 64'(d), 64'(exp_dat(2)));
   endtask

   task automatic t_fn_masked;
      logic [31:0] d;
      set_fn(0, 0);
      wr(1, 1*16 + 12, 0);
      irq(1);
      #1 chk("R3 disabled no message", 64'(msg_valid), 64'd0);
      rd(0, 0, d); chk("R3 parked while disabled", 64'(d), 64'h2);
      wr(1, 1*16 + 12, 1);
      set_fn(1, 0);
      #1 chk("R3 self-masked still parked", 64'(msg_valid), 64'd0);
      wr(1, 1*16 + 12, 0);
      take("R6 unmask replay", 1);
      #1 chk("R6 no second message", 64'(msg_valid), 64'd0);
      rd(0, 0, d); chk("R6 pending cleared", 64'(d), 64'd0);
   endtask

   task automatic t_direct;
      logic [31:0] d;
      wr(1, 0*16 + 12, 0);
      irq(0);
      rd(0, 0, d); chk("R4 pending until accept", 64'(d), 64'h1);
      take("R4 direct send", 0);
      rd(0, 0, d); chk("R4 pending cleared", 64'(d), 64'd0);
   endtask

   task automatic t_drop;
      logic [31:0] d;
      wr(1, 7*16 + 12, 0);
      irq(7);
      irq(9);
      irq(2047);
      #1 chk("R8 dropped no message", 64'(msg_valid), 64'd0);
      rd(0, 0, d); chk("R8 dropped not pending", 64'(d), 64'd0);
   endtask

   task automatic t_pba_write;
      logic [31:0] d;
      set_fn(1, 1);
      wr(0, 0, 32'hFFFF_FFFF);
      rd(0, 0, d); chk("R9 write no set", 64'(d), 64'd0);
      irq(3);
      wr(0, 0, 32'h0);
      rd(0, 0, d); chk("R5 bit3 kept after pba write R9", 64'(d), 64'h8);
      rd(0, 4, d); chk("R9 upper word zero", 64'(d), 64'd0);
   endtask

   task automatic t_replay;
      logic [31:0] d;
      wr(1, 2*16 + 12, 0);
      wr(1, 4*16 + 12, 0);
      wr(1, 5*16 + 12, 0);
      irq(5); irq(2); irq(4);
      rd(0, 0, d); chk("R5 pending bits", 64'(d), 64'h3C);
      #1 chk("R3 maskall holds", 64'(msg_valid), 64'd0);
      set_fn(1, 0);
      take("R7 first", 2);
      take("R7 second", 4);
      take("R7 third", 5);
      #1 chk("R7 drained", 64'(msg_valid), 64'd0);
      rd(0, 0, d); chk("R7 self-masked stays", 64'(d), 64'h8);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_program();
      t_fn_masked();
      t_direct();
      t_drop();
      t_pba_write();
      t_replay();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule